// File: doc/BRIEF.md
# Ternary Weight Quantizer

The block takes in one weight matrix as a stream of signed fixed-point words and turns it into three-level codes with one scale shared by the whole matrix. While the words arrive it keeps a copy of each one on chip and adds up their magnitudes. When the word flagged as last is accepted, the sum is divided by the fixed matrix size to give the scale, which is the mean magnitude. The block then reads its copy back and emits one 2-bit code per weight, in arrival order.

A weight becomes the code for sign(w) when its magnitude is at least half the scale, and 0 otherwise. This gives round(w/scale) clamped to [-1, +1] with ties rounded away from zero, and no divider is needed. The matrix size is a power of two set by a parameter, so the mean is a right shift. A matrix is expected to hold exactly that many words. The input stall is the only flow control: the block stops accepting words from the moment the scale is computed until the last code has gone out.

Top module: `ternary_quant`

## Requirements
- R1: Codes are 2-bit two's complement: 2'b11 means -1, 2'b00 means 0 and 2'b01 means +1. The value 2'b10 never appears while `code_valid_o` is high.
- R2: `scale_o` equals the sum of the magnitudes of all weights in the matrix, shifted right by `N_LOG2` (floor of the mean). It is an unsigned `W_W`-bit value, and the most negative weight counts as magnitude 2^(W_W-1).
- R3: When the scale is non-zero, a weight is coded as sign(w) if 2*|w| >= scale, and as 0 otherwise. A tie (2*|w| == scale) therefore gives +1 or -1.
- R4: When the scale is 0, every code of that matrix is 2'b00, including the codes of non-zero weights.
- R5: `scale_valid_o` is high for exactly one cycle, the cycle after the last weight is accepted. Codes follow from the next cycle on, one per cycle, in input order. `code_last_o` is high with the final code only.
- R6: `w_ready_o` is low from the scale cycle until the final code has been emitted. Words offered during that time are not taken and do not change the next matrix's results.
- R7: `scale_o` holds its value after the codes end, and changes only on a clock edge that accepts a last weight.
- R8: After reset, `w_ready_o` is high, `scale_valid_o` and `code_valid_o` are low, and `scale_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| w_valid_i | input | 1 | Weight word valid |
| w_data_i | input | W_W | Signed weight |
| w_last_i | input | 1 | Marks the final weight of the matrix |
| w_ready_o | output | 1 | Block can accept a weight |
| scale_o | output | W_W | Unsigned per-matrix scale (mean magnitude) |
| scale_valid_o | output | 1 | One-cycle pulse, scale is fresh |
| code_valid_o | output | 1 | `code_o` carries a code this cycle |
| code_o | output | 2 | Ternary code, two's complement |
| code_last_o | output | 1 | Marks the final code of the matrix |

## Verification
Some properties are checked on every cycle: no illegal code value, the zero-scale forcing, the pulse-then-codes ordering, the stall of the input during the output phase, and a scale that moves only when a last weight is accepted. The arithmetic can only be shown by the bench's scenarios, which compare against a model written from the rules above. This covers the floor of the mean, the half-scale threshold with its tie case, the magnitude of the most negative word, a sum so small that its mean truncates to zero, and the refusal of words offered during the output phase.

// File: rtl/ternary_quant_pkg.sv
package ternary_quant_pkg;
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_SCALE = 2'd1,
    ST_EMIT  = 2'd2
  } state_e;

  localparam logic [1:0] CODE_POS  = 2'b01;
  localparam logic [1:0] CODE_ZERO = 2'b00;
  localparam logic [1:0] CODE_NEG  = 2'b11;
endpackage

// File: rtl/ternary_abs_acc.sv
module ternary_abs_acc #(
  parameter int W_W    = 8,
  parameter int N_LOG2 = 3,
  localparam int SW    = W_W + N_LOG2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  add_i,
  input  logic                  clr_i,
  input  logic signed [W_W-1:0] w_i,
  output logic [SW-1:0]         next_sum_o
);
  logic [W_W-1:0] mag;
  logic [SW-1:0]  sum_q;

  // unsigned magnitude; the most negative word maps to 2^(W_W-1)
  assign mag        = w_i[W_W-1] ? (~w_i + 1'b1) : w_i;
  assign next_sum_o = sum_q + SW'(mag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (add_i) sum_q <= next_sum_o;
  end
endmodule

// File: rtl/ternary_wbuf.sv
module ternary_wbuf #(
  parameter int W_W   = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic signed [W_W-1:0] wr_data_i,
  input  logic [AW-1:0]         rd_addr_i,
  output logic signed [W_W-1:0] rd_data_o
);
  logic signed [W_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_addr_i == AW'(g))) mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ternary_coder.sv
module ternary_coder
  import ternary_quant_pkg::*;
#(
  parameter int W_W = 8
) (
  input  logic signed [W_W-1:0] w_i,
  input  logic [W_W-1:0]        scale_i,
  output logic [1:0]            code_o
);
  logic [W_W-1:0] mag;
  logic [W_W:0]   mag_x2;

  assign mag    = w_i[W_W-1] ? (~w_i + 1'b1) : w_i;
  assign mag_x2 = {mag, 1'b0};

  // 2|w| >= s  <=>  |w|/s >= 0.5, ties rounded away from zero
  always_comb begin
    if (scale_i == '0)                      code_o = CODE_ZERO;
    else if (mag_x2 >= {1'b0, scale_i})     code_o = w_i[W_W-1] ? CODE_NEG : CODE_POS;
    else                                    code_o = CODE_ZERO;
  end
endmodule

// File: rtl/ternary_quant.sv
module ternary_quant
  import ternary_quant_pkg::*;
#(
  parameter int W_W    = 8,
  parameter int N_LOG2 = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  w_valid_i,
  input  logic signed [W_W-1:0] w_data_i,
  input  logic                  w_last_i,
  output logic                  w_ready_o,
  output logic [W_W-1:0]        scale_o,
  output logic                  scale_valid_o,
  output logic                  code_valid_o,
  output logic [1:0]            code_o,
  output logic                  code_last_o
);
  localparam int DEPTH = 1 << N_LOG2;
  localparam int AW    = N_LOG2;
  localparam int SW    = W_W + N_LOG2;

  state_e                state_q;
  logic [AW-1:0]         wr_idx_q, rd_idx_q, end_idx_q;
  logic [W_W-1:0]        scale_q;
  logic                  accept, accept_last;
  logic [SW-1:0]         next_sum;
  logic [SW-1:0]         mean;
  logic signed [W_W-1:0] rd_data;

  assign w_ready_o   = (state_q == ST_LOAD);
  assign accept      = w_valid_i && w_ready_o;
  assign accept_last = accept && w_last_i;
  assign mean        = next_sum >> N_LOG2;

  ternary_abs_acc #(.W_W(W_W), .N_LOG2(N_LOG2)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .add_i      (accept && !w_last_i),
    .clr_i      (accept_last),
    .w_i        (w_data_i),
    .next_sum_o (next_sum)
  );

  ternary_wbuf #(.W_W(W_W), .DEPTH(DEPTH)) u_buf (
    .clk_i     (clk_i),
    .wr_en_i   (accept),
    .wr_addr_i (wr_idx_q),
    .wr_data_i (w_data_i),
    .rd_addr_i (rd_idx_q),
    .rd_data_o (rd_data)
  );

  ternary_coder #(.W_W(W_W)) u_coder (
    .w_i     (rd_data),
    .scale_i (scale_q),
    .code_o  (code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_LOAD;
      wr_idx_q  <= '0;
      rd_idx_q  <= '0;
      end_idx_q <= '0;
      scale_q   <= '0;
    end else begin
      unique case (state_q)
        ST_LOAD: if (accept) begin
          wr_idx_q <= wr_idx_q + 1'b1;
          if (w_last_i) begin
            end_idx_q <= wr_idx_q;
            wr_idx_q  <= '0;
            scale_q   <= mean[W_W-1:0];
            state_q   <= ST_SCALE;
          end
        end
        ST_SCALE: begin
          rd_idx_q <= '0;
          state_q  <= ST_EMIT;
        end
        ST_EMIT: begin
          rd_idx_q <= rd_idx_q + 1'b1;
          if (rd_idx_q == end_idx_q) state_q <= ST_LOAD;
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  assign scale_o       = scale_q;
  assign scale_valid_o = (state_q == ST_SCALE);
  assign code_valid_o  = (state_q == ST_EMIT);
  assign code_last_o   = code_valid_o && (rd_idx_q == end_idx_q);
endmodule

// File: rtl/ternary_quant_chk.sv
module ternary_quant_chk #(
  parameter int W_W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           w_valid_i,
  input logic           w_last_i,
  input logic           w_ready_o,
  input logic [W_W-1:0] scale_o,
  input logic           scale_valid_o,
  input logic           code_valid_o,
  input logic [1:0]     code_o,
  input logic           code_last_o
);
  // R1
  code_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o |-> (code_o != 2'b10));

  // R4
  zero_scale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_valid_o && (scale_o == '0)) |-> (code_o == 2'b00));

  // R5
  pulse_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_valid_i && w_ready_o && w_last_i) |=> scale_valid_o);

  // R5
  codes_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scale_valid_o |=> (code_valid_o && !scale_valid_o));

  // R5
  last_only_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_last_o |-> code_valid_o);

  // R6
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scale_valid_o || code_valid_o) |-> !w_ready_o);

  // R7
  scale_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_valid_i && w_ready_o && w_last_i) |=> $stable(scale_o));
endmodule

bind ternary_quant ternary_quant_chk #(.W_W(W_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .w_valid_i     (w_valid_i),
  .w_last_i      (w_last_i),
  .w_ready_o     (w_ready_o),
  .scale_o       (scale_o),
  .scale_valid_o (scale_valid_o),
  .code_valid_o  (code_valid_o),
  .code_o        (code_o),
  .code_last_o   (code_last_o)
);

// File: tb/ternary_quant_bench.sv
`timescale 1ns/1ps
module ternary_quant_bench;
  localparam int W_W  = 8;
  localparam int NL   = 3;
  localparam int N    = 1 << NL;
  localparam int NVEC = 4;

  typedef logic signed [W_W-1:0] mat_t [N];

  localparam logic signed [W_W-1:0] VEC [NVEC][N] = '{
    '{8'sd10, -8'sd10, 8'sd3, -8'sd4, 8'sd0, 8'sd20, -8'sd2, 8'sd1},
    '{8'sd4, -8'sd4, 8'sd3, -8'sd3, 8'sd20, -8'sd20, 8'sd5, 8'sd5},
    '{-8'sd128, 8'sd127, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0},
    '{-8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128, -8'sd128}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic w_valid = 1'b0, w_last = 1'b0;
  logic signed [W_W-1:0] w_data = '0;
  logic w_ready, scale_valid, code_valid, code_last;
  logic [W_W-1:0] scale;
  logic [1:0] code;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ternary_quant #(.W_W(W_W), .N_LOG2(NL)) u_ternary_quant (
    .clk_i(clk), .rst_ni(rst_n), .w_valid_i(w_valid), .w_data_i(w_data),
    .w_last_i(w_last), .w_ready_o(w_ready), .scale_o(scale),
    .scale_valid_o(scale_valid), .code_valid_o(code_valid), .code_o(code),
    .code_last_o(code_last));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mag(input int w);
    return (w < 0) ? -w : w;
  endfunction

  function automatic int exp_scale(input mat_t m);
    int s = 0;
    for (int i = 0; i < N; i++) s += mag(int'(m[i]));
    return s >> NL;
  endfunction

  function automatic int exp_code(input int w, input int s);
    if (s == 0 || 2 * mag(w) < s) return 0;
    return (w < 0) ? 3 : 1;
  endfunction

  // drives one matrix, then checks scale pulse and all codes;
  // poke=1 keeps offering junk words during the output phase (R6)
  task automatic run_mat(input mat_t m, input bit poke);
    int s;
    s = exp_scale(m);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      w_valid = 1'b1; w_data = m[i]; w_last = (i == N - 1);
    end
    @(negedge clk);
    w_valid = poke; w_data = 8'sd127; w_last = poke;
    check("R5 scale_valid pulse", int'(scale_valid), 1);
    check("R2 scale value", int'(scale), s);
    check("R6 ready low in scale cycle", int'(w_ready), 0);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      check("R5 code_valid", int'(code_valid), 1);
      check("R5 no second pulse", int'(scale_valid), 0);
      if (s == 0) check("R4 forced zero code", int'(code), 0);
      else        check("R3 code value", int'(code), exp_code(int'(m[k]), s));
      check("R1 legal code", int'(code == 2'b10), 0);
      check("R5 code_last", int'(code_last), int'(k == N - 1));
      if (poke) check("R6 ready low while emitting", int'(w_ready), 0);
    end
    @(negedge clk);
    w_valid = 1'b0; w_last = 1'b0;
    check("R5 codes end", int'(code_valid), 0);
    check("R6 ready back", int'(w_ready), 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    mat_t m;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 ready", int'(w_ready), 1);
    check("R8 scale_valid", int'(scale_valid), 0);
    check("R8 code_valid", int'(code_valid), 0);
    check("R8 scale", int'(scale), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < N; i++) m[i] = VEC[v][i];
      run_mat(m, 1'b0);
    end

    // R2 R3 most negative word magnitude: last vector gives scale 128
    check("R2 full-scale magnitude", int'(scale), 128);

    // R7 scale holds after the codes end
    repeat (5) @(negedge clk);
    check("R7 scale held", int'(scale), 128);

    // R4 all-zero matrix
    for (int i = 0; i < N; i++) m[i] = '0;
    run_mat(m, 1'b0);

    // R4 small sum truncates to scale 0, non-zero weight still coded 0
    for (int i = 0; i < N; i++) m[i] = '0;
    m[0] = 8'sd1; m[3] = -8'sd6;
    run_mat(m, 1'b0);

    // R6 junk offered during output phase is refused
    for (int i = 0; i < N; i++) m[i] = 8'(i * 3 - 10);
    run_mat(m, 1'b1);
    // next matrix must be unaffected by the refused words
    for (int i = 0; i < N; i++) m[i] = VEC[1][i];
    run_mat(m, 1'b0);
    check("R6 next matrix scale", int'(scale), 8);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule